// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is a serial peripheral interface master that works through a queue of up to sixteen byte transfers with no help from the host once started. Three small internal memories hold the outgoing bytes, the incoming bytes and one command byte per queue entry. A command byte carries the code driven on the peripheral-select outputs during that transfer and a control bit that suppresses storing the received byte.

The host fills the memories and programs a start index, an end index, a wrap enable, a halt request, an interrupt enable, the idle value of the select outputs and the serial clock divider, all through a simple byte-wide register port. A write with the start bit set launches the engine. It walks the entries in ascending order, modulo sixteen, from the start index to the end index. It then stops, or with wrap enabled begins again at the start index. A halt request is honoured only after the end entry. Status reports a finished flag, a halt acknowledge and the index of the last completed entry.

Top module: `spi_queue_master`

## Requirements
- R1: After reset the divider reads 4, the select outputs equal 4'hF, sck is low, irq is low and status (offset 5) reads 0.
- R2: With a divider value d of 2 to 255 (offset 0), each high and each low half of sck inside a transfer lasts exactly d system clock cycles, so the serial clock is the system clock divided by 2*d.
- R3: With a divider value of 0 or 1, a start write is ignored: sck makes no edge, no byte is shifted and the select outputs keep their idle value.
- R4: Each transfer moves 8 bits MSB first; mosi changes only on falling sck edges and miso is sampled on rising edges. The received byte is stored at the same index in the receive memory (page 1) unless bit 4 of that entry's command byte is set, in which case the stored byte is left unchanged.
- R5: The select outputs carry bits [3:0] of the entry's command byte for the whole transfer and return to the programmed idle value (offset 4) between any two transfers.
- R6: Entries run from the start index (offset 1) to the end index (offset 2) in ascending order, passing from 15 to 0.
- R7: Completing the end entry sets status bit 0; without wrap the engine then stops.
- R8: With wrap enabled (control offset 3, bit 1) the engine restarts at the start index after each end entry.
- R9: A halt request (control bit 2) stops the engine only after an end entry, then sets status bit 1; that bit clears when the request is withdrawn.
- R10: Completed-pointer register (offset 6) reads the index of the last finished entry.
- R11: irq equals status bit 0 AND the interrupt enable (control bit 3); writing 1 to status bit 0 clears the finished flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register port write strobe |
| reg_addr | input | 6 | Bits [5:4] page (0 transmit, 1 receive, 2 command, 3 control), bits [3:0] index or offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| miso | input | 1 | Serial data from the peripheral |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the peripheral |
| pcs | output | 4 | Peripheral-select code |
| irq | output | 1 | Queue-finished interrupt |

## Verification
The bench sweeps the divider across several values and measures every half period of sck inside a transfer; a divider that counted from one or off by one would show periods one cycle short or long. Queues crossing from index 15 to 0 target a pointer that saturates or wraps to the start index instead. A halt raised in the middle of a wrapping queue must still stop after the end entry, so a design that halted at the next transfer would leave an odd transfer count and the wrong completed pointer. Divider values 0 and 1, the store-suppress bit and a changed idle select value each target a design that shifts anyway, overwrites the receive byte or drives a stale select code between transfers.

// File: rtl/sqm_pkg.sv
package sqm_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_XFER,
        SQ_GAP
    } sq_state_e;

    // register port pages
    localparam logic [1:0] PG_TX  = 2'd0;
    localparam logic [1:0] PG_RX  = 2'd1;
    localparam logic [1:0] PG_CMD = 2'd2;
    localparam logic [1:0] PG_REG = 2'd3;

    // offsets inside the control page
    localparam int unsigned OFS_DIV    = 0;
    localparam int unsigned OFS_NEWP   = 1;
    localparam int unsigned OFS_ENDP   = 2;
    localparam int unsigned OFS_CTRL   = 3;
    localparam int unsigned OFS_IDLECS = 4;
    localparam int unsigned OFS_STAT   = 5;
    localparam int unsigned OFS_CPL    = 6;

    // control register bits
    localparam int unsigned CTL_GO   = 0;
    localparam int unsigned CTL_WRAP = 1;
    localparam int unsigned CTL_HALT = 2;
    localparam int unsigned CTL_IE   = 3;

endpackage

// File: rtl/sqm_baud.sv
module sqm_baud #(
    parameter int unsigned DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    typedef struct packed {
        logic [DIVW-1:0] cnt;
    } baud_t;

    baud_t s_q, s_d;
    logic  en;

    always_comb begin
        s_d  = s_q;
        en   = run && (div > DIVW'(1));
        tick = en && (s_q.cnt == div - DIVW'(1));
        if (!en || tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + DIVW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/sqm_shifter.sv
module sqm_shifter #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] tx,
    input  logic          tick,
    input  logic          miso,
    output logic          sck,
    output logic          mosi,
    output logic          busy,
    output logic          fin,
    output logic [DW-1:0] rx
);
    localparam int unsigned BCW = $clog2(DW);

    typedef struct packed {
        logic [DW-1:0]  shreg;
        logic [DW-1:0]  rxreg;
        logic [BCW-1:0] bitcnt;
        logic           busy;
        logic           sck;
        logic           fin;
    } shf_t;

    shf_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        s_d.fin = 1'b0;
        if (start && !s_q.busy) begin
            s_d.shreg  = tx;
            s_d.busy   = 1'b1;
            s_d.sck    = 1'b0;
            s_d.bitcnt = '0;
        end else if (s_q.busy && tick) begin
            if (!s_q.sck) begin
                s_d.sck   = 1'b1;
                s_d.rxreg = {s_q.rxreg[DW-2:0], miso};
            end else begin
                s_d.sck = 1'b0;
                if (s_q.bitcnt == BCW'(DW - 1)) begin
                    s_d.busy = 1'b0;
                    s_d.fin  = 1'b1;
                end else begin
                    s_d.shreg  = {s_q.shreg[DW-2:0], 1'b0};
                    s_d.bitcnt = s_q.bitcnt + BCW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sck  = s_q.sck;
    assign mosi = s_q.shreg[DW-1];
    assign busy = s_q.busy;
    assign fin  = s_q.fin;
    assign rx   = s_q.rxreg;

    AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && $past(s_q.busy) && !$stable(s_q.shreg[DW-1])) |-> $fell(s_q.sck)); // R4
    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.bitcnt <= BCW'(DW - 1))); // R4

endmodule

// File: rtl/sqm_sequencer.sv
module sqm_sequencer
    import sqm_pkg::*;
#(
    parameter int unsigned QD  = 16,
    parameter int unsigned CSW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   go,
    input  logic                   div_ok,
    input  logic [$clog2(QD)-1:0]  new_ptr,
    input  logic [$clog2(QD)-1:0]  end_ptr,
    input  logic                   wrap_en,
    input  logic                   halt_req,
    input  logic                   done_clr,
    input  logic [CSW-1:0]         cmd_cs,
    input  logic [CSW-1:0]         cs_idle,
    input  logic                   xfer_fin,
    output logic [$clog2(QD)-1:0]  ptr,
    output logic                   start,
    output logic [CSW-1:0]         cs,
    output logic                   rx_we,
    output logic                   done_flag,
    output logic                   halt_ack,
    output logic [$clog2(QD)-1:0]  cpl_ptr
);
    localparam int unsigned PW = $clog2(QD);

    typedef struct packed {
        sq_state_e      state;
        logic [PW-1:0]  ptr;
        logic [CSW-1:0] cs;
        logic           start;
        logic           done;
        logic           hack;
        logic [PW-1:0]  cpl;
    } seq_t;

    seq_t s_q, s_d;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.hack  = s_q.hack && halt_req;
        rx_we     = 1'b0;
        if (done_clr) begin
            s_d.done = 1'b0;
        end
        unique case (s_q.state)
            SQ_IDLE: begin
                s_d.cs = cs_idle;
                if (go && div_ok) begin
                    s_d.ptr   = new_ptr;
                    s_d.state = SQ_LOAD;
                end
            end
            SQ_LOAD: begin
                s_d.cs    = cmd_cs;
                s_d.start = 1'b1;
                s_d.state = SQ_XFER;
            end
            SQ_XFER: begin
                if (xfer_fin) begin
                    rx_we   = 1'b1;
                    s_d.cs  = cs_idle;
                    s_d.cpl = s_q.ptr;
                    if (s_q.ptr == end_ptr) begin
                        s_d.done = 1'b1;
                        if (halt_req) begin
                            s_d.hack  = 1'b1;
                            s_d.state = SQ_IDLE;
                        end else if (wrap_en) begin
                            s_d.ptr   = new_ptr;
                            s_d.state = SQ_GAP;
                        end else begin
                            s_d.state = SQ_IDLE;
                        end
                    end else begin
                        s_d.ptr   = s_q.ptr + PW'(1);
                        s_d.state = SQ_GAP;
                    end
                end
            end
            SQ_GAP: begin
                s_d.cs    = cs_idle;
                s_d.state = SQ_LOAD;
            end
            default: s_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= SQ_IDLE;
            s_q.cs    <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ptr       = s_q.ptr;
    assign start     = s_q.start;
    assign cs        = s_q.cs;
    assign done_flag = s_q.done;
    assign halt_ack  = s_q.hack;
    assign cpl_ptr   = s_q.cpl;

    AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == SQ_XFER && $past(s_q.state) == SQ_XFER) |-> $stable(s_q.cs)); // R5
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.done) |-> (s_q.cpl == end_ptr)); // R7
    AST_HALT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.hack) |-> (s_q.cpl == end_ptr && s_q.state == SQ_IDLE)); // R9
    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == SQ_IDLE && !div_ok) |=> (s_q.state == SQ_IDLE)); // R3

endmodule

// File: rtl/spi_queue_master.sv
module spi_queue_master
    import sqm_pkg::*;
#(
    parameter int unsigned QD      = 16,
    parameter int unsigned DW      = 8,
    parameter int unsigned CSW     = 4,
    parameter int unsigned DIVW    = 8,
    parameter int unsigned DIV_RST = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_we,
    input  logic [$clog2(QD)+1:0]         reg_addr,
    input  logic [DW-1:0]                 reg_wdata,
    output logic [DW-1:0]                 reg_rdata,
    input  logic                          miso,
    output logic                          sck,
    output logic                          mosi,
    output logic [CSW-1:0]                pcs,
    output logic                          irq
);
    localparam int unsigned PW    = $clog2(QD);
    localparam int unsigned ADDRW = PW + 2;
    localparam int unsigned NOST  = CSW;   // command bit that suppresses the receive store

    typedef struct packed {
        logic [DIVW-1:0] div;
        logic [PW-1:0]   newp;
        logic [PW-1:0]   endp;
        logic            wrap;
        logic            halt;
        logic            ie;
        logic [CSW-1:0]  csidle;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    logic [1:0]    page;
    logic [PW-1:0] idx;
    logic          reg_wr;
    logic          go;
    logic          done_clr;

    logic [DW-1:0] tx_ram  [QD];
    logic [DW-1:0] rx_ram  [QD];
    logic [DW-1:0] cmd_ram [QD];

    logic          tick;
    logic          sh_busy;
    logic          sh_fin;
    logic [DW-1:0] sh_rx;
    logic [PW-1:0] seq_ptr;
    logic          seq_start;
    logic          seq_rx_we;
    logic          done_flag;
    logic          halt_ack;
    logic [PW-1:0] cpl_ptr;
    logic          div_ok;

    assign page   = reg_addr[ADDRW-1 -: 2];
    assign idx    = reg_addr[PW-1:0];
    assign reg_wr = reg_we && (page == PG_REG);
    assign div_ok = cfg_q.div > DIVW'(1);

    // configuration registers
    always_comb begin
        cfg_d    = cfg_q;
        go       = 1'b0;
        done_clr = 1'b0;
        if (reg_wr) begin
            case (idx)
                PW'(OFS_DIV):    cfg_d.div    = DIVW'(reg_wdata);
                PW'(OFS_NEWP):   cfg_d.newp   = reg_wdata[PW-1:0];
                PW'(OFS_ENDP):   cfg_d.endp   = reg_wdata[PW-1:0];
                PW'(OFS_CTRL): begin
                    go         = reg_wdata[CTL_GO];
                    cfg_d.wrap = reg_wdata[CTL_WRAP];
                    cfg_d.halt = reg_wdata[CTL_HALT];
                    cfg_d.ie   = reg_wdata[CTL_IE];
                end
                PW'(OFS_IDLECS): cfg_d.csidle = reg_wdata[CSW-1:0];
                PW'(OFS_STAT):   done_clr     = reg_wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q        <= '0;
            cfg_q.div    <= DIVW'(DIV_RST);
            cfg_q.csidle <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // queue memories: host writes transmit and command, engine writes receive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < QD; i++) begin
                tx_ram[i]  <= '0;
                cmd_ram[i] <= '0;
            end
        end else if (reg_we) begin
            if (page == PG_TX)  tx_ram[idx]  <= reg_wdata;
            if (page == PG_CMD) cmd_ram[idx] <= reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < QD; i++) begin
                rx_ram[i] <= '0;
            end
        end else if (seq_rx_we && !cmd_ram[seq_ptr][NOST]) begin
            rx_ram[seq_ptr] <= sh_rx;
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (page)
            PG_TX:  reg_rdata = tx_ram[idx];
            PG_RX:  reg_rdata = rx_ram[idx];
            PG_CMD: reg_rdata = cmd_ram[idx];
            default: begin
                case (idx)
                    PW'(OFS_DIV):    reg_rdata = DW'(cfg_q.div);
                    PW'(OFS_NEWP):   reg_rdata = DW'(cfg_q.newp);
                    PW'(OFS_ENDP):   reg_rdata = DW'(cfg_q.endp);
                    PW'(OFS_CTRL):   reg_rdata = DW'({cfg_q.ie, cfg_q.halt, cfg_q.wrap, 1'b0});
                    PW'(OFS_IDLECS): reg_rdata = DW'(cfg_q.csidle);
                    PW'(OFS_STAT):   reg_rdata = DW'({halt_ack, done_flag});
                    PW'(OFS_CPL):    reg_rdata = DW'(cpl_ptr);
                    default:         reg_rdata = '0;
                endcase
            end
        endcase
    end

    sqm_baud #(.DIVW(DIVW)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sh_busy),
        .div   (cfg_q.div),
        .tick  (tick)
    );

    sqm_shifter #(.DW(DW)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (seq_start),
        .tx    (tx_ram[seq_ptr]),
        .tick  (tick),
        .miso  (miso),
        .sck   (sck),
        .mosi  (mosi),
        .busy  (sh_busy),
        .fin   (sh_fin),
        .rx    (sh_rx)
    );

    sqm_sequencer #(.QD(QD), .CSW(CSW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .div_ok    (div_ok),
        .new_ptr   (cfg_q.newp),
        .end_ptr   (cfg_q.endp),
        .wrap_en   (cfg_q.wrap),
        .halt_req  (cfg_q.halt),
        .done_clr  (done_clr),
        .cmd_cs    (cmd_ram[seq_ptr][CSW-1:0]),
        .cs_idle   (cfg_q.csidle),
        .xfer_fin  (sh_fin),
        .ptr       (seq_ptr),
        .start     (seq_start),
        .cs        (pcs),
        .rx_we     (seq_rx_we),
        .done_flag (done_flag),
        .halt_ack  (halt_ack),
        .cpl_ptr   (cpl_ptr)
    );

    assign irq = done_flag && cfg_q.ie;

    AST_SCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.div < DIVW'(2)) |=> $stable(sck)); // R3
    AST_PCS_DURING_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_busy && $past(sh_busy)) |-> $stable(pcs)); // R5
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_busy && !$past(sh_busy)) |-> !sck); // R2

endmodule

// File: tb/sim_spi_queue_master.sv
`timescale 1ns/1ps
module sim_spi_queue_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       miso;
    logic       sck;
    logic       mosi;
    logic [3:0] pcs;
    logic       irq;

    int nchk = 0;
    int nbad = 0;

    always #2 clk = ~clk;
    assign miso = ~mosi;

    spi_queue_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .miso(miso),
        .sck(sck), .mosi(mosi), .pcs(pcs), .irq(irq)
    );

    // serial monitor
    int         nlog = 0;
    int         nb = 0;
    logic [7:0] cap = '0;
    logic [3:0] ccur = '0;
    int         csmis = 0;
    logic [7:0] logb [256];
    logic [3:0] logc [256];

    always @(posedge sck) begin
        if (nb % 8 == 0) ccur = pcs;
        else if (pcs != ccur) csmis++;
        cap = {cap[6:0], mosi};
        nb++;
        if (nb % 8 == 0) begin
            logb[nlog % 256] = cap;
            logc[nlog % 256] = ccur;
            nlog++;
        end
    end

    // half-period and gap monitor
    logic       psck = 1'b0;
    logic       sawfall = 1'b0;
    int         run = 0;
    int         hi_len = 0;
    int         lo_len = 0;
    logic [3:0] idle_exp = 4'hF;
    logic [3:0] pcs_prev = 4'hF;
    int         gaps = 0;

    always @(negedge clk) begin
        if (sck == psck) run++;
        else begin
            if (psck) hi_len = run;
            else if (sawfall && (nb % 8 != 1)) lo_len = run;
            sawfall = psck;
            run = 1;
        end
        psck = sck;
        if (rst_n && pcs == idle_exp && pcs_prev != idle_exp) gaps++;
        pcs_prev = pcs;
    end

    function automatic logic [7:0] txv(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    function automatic logic [5:0] adr(input logic [1:0] pg, input int i);
        return {pg, 4'(i)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_stat(input int b);
        logic [7:0] v;
        for (int k = 0; k < 20000; k++) begin
            rd(adr(2'd3, 5), v);
            if (v[b]) return;
        end
    endtask

    task automatic wait_log(input int target);
        for (int k = 0; k < 40000; k++) begin
            @(negedge clk);
            if (nlog >= target) return;
        end
    endtask

    task automatic run_q(input int np, input int ep, input logic [7:0] ctl);
        wr(adr(2'd3, 1), 8'(np));
        wr(adr(2'd3, 2), 8'(ep));
        wr(adr(2'd3, 3), ctl | 8'h01);
    endtask

    task automatic run_all();
        logic [7:0] v;
        int n0, g0, d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(adr(2'd3, 0), v); chk(v == 8'd4, "R1 divider", v, 4);
        rd(adr(2'd3, 5), v); chk(v == 8'd0, "R1 status", v, 0);
        chk(pcs == 4'hF, "R1 pcs", pcs, 15);
        chk(sck == 1'b0 && irq == 1'b0, "R1 sck/irq", {sck, irq}, 0);

        for (int i = 0; i < 16; i++) begin
            wr(adr(2'd0, i), txv(i));
            wr(adr(2'd2, i), 8'(i % 10));
        end

        // basic queue 0..3 at default divider
        n0 = nlog; g0 = gaps;
        run_q(0, 3, 8'h00);
        wait_stat(0);
        chk(nlog - n0 == 4, "R6 count", nlog - n0, 4);
        for (int i = 0; i < 4; i++) begin
            chk(logb[(n0 + i) % 256] == txv(i), "R4 mosi byte", logb[(n0 + i) % 256], txv(i));
            chk(logc[(n0 + i) % 256] == 4'(i % 10), "R5 pcs code", logc[(n0 + i) % 256], i % 10);
            rd(adr(2'd1, i), v); chk(v == ~txv(i), "R4 rx store", v, ~txv(i));
        end
        chk(csmis == 0, "R5 pcs held", csmis, 0);
        chk(gaps - g0 == 4, "R5 idle gaps", gaps - g0, 4);
        chk(hi_len == 4 && lo_len == 4, "R2 default halves", hi_len * 16 + lo_len, 8'h44);
        rd(adr(2'd3, 6), v); chk(v == 8'd3, "R10 completed ptr", v, 3);
        chk(irq == 1'b0, "R11 irq masked", irq, 0);
        n0 = nlog;
        repeat (200) @(negedge clk);
        chk(nlog == n0 && sck == 1'b0, "R7 stopped", nlog - n0, 0);
        wr(adr(2'd3, 3), 8'h08);
        @(negedge clk); chk(irq == 1'b1, "R11 irq set", irq, 1);
        wr(adr(2'd3, 5), 8'h01);
        @(negedge clk); chk(irq == 1'b0, "R11 irq cleared", irq, 0);
        rd(adr(2'd3, 5), v); chk(v[0] == 1'b0, "R11 done cleared", v, 0);
        wr(adr(2'd3, 3), 8'h00);

        // R2 divider sweep
        for (int dv = 2; dv <= 7; dv++) begin
            wr(adr(2'd3, 0), 8'(dv));
            n0 = nlog;
            run_q(dv, dv, 8'h00);
            wait_stat(0);
            wr(adr(2'd3, 5), 8'h01);
            chk(hi_len == dv, "R2 high half", hi_len, dv);
            chk(lo_len == dv, "R2 low half", lo_len, dv);
            chk(logb[n0 % 256] == txv(dv), "R4 byte in sweep", logb[n0 % 256], txv(dv));
        end

        // R6 index wraps from 15 to 0
        wr(adr(2'd3, 0), 8'd3);
        n0 = nlog;
        run_q(14, 1, 8'h00);
        wait_stat(0);
        wr(adr(2'd3, 5), 8'h01);
        for (int i = 0; i < 4; i++) begin
            d = (14 + i) % 16;
            chk(logb[(n0 + i) % 256] == txv(d), "R6 order across 15", logb[(n0 + i) % 256], txv(d));
        end
        rd(adr(2'd3, 6), v); chk(v == 8'd1, "R10 completed ptr wrap", v, 1);

        // R4 store suppress
        wr(adr(2'd0, 5), 8'h0F);
        run_q(5, 5, 8'h00); wait_stat(0); wr(adr(2'd3, 5), 8'h01);
        rd(adr(2'd1, 5), v); chk(v == 8'hF0, "R4 stored", v, 8'hF0);
        wr(adr(2'd2, 5), 8'h15); wr(adr(2'd0, 5), 8'h55);
        n0 = nlog;
        run_q(5, 5, 8'h00); wait_stat(0); wr(adr(2'd3, 5), 8'h01);
        chk(logb[n0 % 256] == 8'h55, "R4 no-store still shifts", logb[n0 % 256], 8'h55);
        rd(adr(2'd1, 5), v); chk(v == 8'hF0, "R4 no-store keeps rx", v, 8'hF0);
        wr(adr(2'd2, 5), 8'h05); wr(adr(2'd0, 5), txv(5));

        // R8 wrap then R9 halt at boundary
        wr(adr(2'd3, 0), 8'd2);
        n0 = nlog;
        run_q(2, 3, 8'h02);
        wait_log(n0 + 7);
        wr(adr(2'd3, 3), 8'h06);
        wait_stat(1);
        d = nlog - n0;
        chk(d >= 8 && d % 2 == 0, "R8/R9 whole rounds", d, 8);
        chk(logb[(nlog - 1) % 256] == txv(3), "R9 last is end entry", logb[(nlog - 1) % 256], txv(3));
        rd(adr(2'd3, 6), v); chk(v == 8'd3, "R10 ptr at halt", v, 3);
        repeat (200) @(negedge clk);
        chk(nlog - n0 == d, "R9 stopped after halt", nlog - n0, d);
        wr(adr(2'd3, 3), 8'h00);
        rd(adr(2'd3, 5), v); chk(v[1] == 1'b0, "R9 ack clears", v, 1);
        wr(adr(2'd3, 5), 8'h01);

        // R9 halt raised with start still finishes the queue
        n0 = nlog;
        run_q(0, 3, 8'h04);
        wait_stat(1);
        chk(nlog - n0 == 4, "R9 halt waits for end", nlog - n0, 4);
        wr(adr(2'd3, 3), 8'h00); wr(adr(2'd3, 5), 8'h01);

        // R3 divider 0 and 1
        for (int dv = 0; dv < 2; dv++) begin
            wr(adr(2'd3, 0), 8'(dv));
            n0 = nlog;
            run_q(0, 3, 8'h00);
            repeat (300) @(negedge clk);
            chk(nlog == n0 && sck == 1'b0, "R3 no shifting", nlog - n0, 0);
            chk(pcs == 4'hF, "R3 pcs idle", pcs, 15);
            rd(adr(2'd3, 5), v); chk(v == 8'd0, "R3 no completion", v, 0);
        end

        // R5 programmable idle value
        wr(adr(2'd3, 0), 8'd2);
        wr(adr(2'd3, 4), 8'h0A);
        @(negedge clk);
        chk(pcs == 4'hA, "R5 new idle value", pcs, 10);
        idle_exp = 4'hA;
        repeat (2) @(negedge clk);
        g0 = gaps; n0 = nlog;
        run_q(7, 8, 8'h00); wait_stat(0);
        chk(gaps - g0 == 2, "R5 gaps to new idle", gaps - g0, 2);
        chk(logc[n0 % 256] == 4'd7 && logc[(n0 + 1) % 256] == 4'd8, "R5 codes", logc[(n0 + 1) % 256], 8);
        chk(pcs == 4'hA, "R5 idle after queue", pcs, 10);
    endtask

    initial begin
        bit wd;
        wd = 1'b0;
        fork
            run_all();
            begin
                #(190000 * 4);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            nchk++; nbad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule